// File: doc/BRIEF.md
# Peripheral RAM Parity Checker

This block sits beside a peripheral RAM and guards its read path with byte-lane parity. It watches every access the RAM receives. On a write it computes one parity bit for each byte lane of the write data and stores those bits in its own parity RAM, at the same address. On a read it fetches the stored bits, computes fresh parity over the data the peripheral RAM returns, and compares the two.

A mismatch in any lane produces a one-cycle error pulse for the system error collector, together with a mask of the failing lanes. The address of the first failing read is latched and held until software clears it. Any later failure before that clear sets a sticky overflow flag. A configuration input selects odd or even parity. A global enable can switch the comparison off; writes still store parity while it is off.

The peripheral RAM is assumed to return read data in the cycle after the read request.

Top module: `pram_parity_guard`

## Requirements
- R1: On each write (`acc_en`=1, `acc_we`=1) the block stores, for each lane i, the XOR of data bits [8i+7:8i] XOR `cfg_odd`. A later clean read of that address with the same `cfg_odd` reports no error. Writes store parity whatever `cfg_en` is.
- R2: A read request at clock edge E0 has its data on `ram_rdata` before edge E1. If any lane mismatches and the check is enabled, `err_pulse` is high for exactly one cycle, from E1 to E2. `err_pulse` is never high unless a read was requested two edges earlier.
- R3: `err_lanes` bit i is 1, in the same cycle as `err_pulse`, exactly when lane i of the returned data fails its parity comparison. Outside a pulse `err_lanes` is 0.
- R4: A read whose data has an even number of bits flipped in every lane, including none, produces no pulse.
- R5: On the first error while `cap_valid`=0, `cap_valid` goes to 1 and `cap_addr` takes the failing read address, in the same cycle as the pulse.
- R6: While `cap_valid`=1 and no clear is given, `cap_addr` does not change, even when further errors occur.
- R7: An error while `cap_valid`=1 (and no clear in that cycle) sets `cap_overflow`. The flag stays set until a clear and is never set while `cap_valid`=0.
- R8: `cap_clr` high at an edge clears `cap_valid` and `cap_overflow`. If an error is detected at that same edge, it is captured as a new first error: `cap_valid`=1, new `cap_addr`, `cap_overflow`=0.
- R9: With `cfg_en`=0 at edge E1 of a read, no pulse is produced and the capture state is unchanged.
- R10: Reading with a `cfg_odd` value different from the one used at write time makes every lane fail; `err_lanes` is all ones.
- R11: After reset, `err_pulse`, `err_lanes`, `cap_valid`, `cap_addr` and `cap_overflow` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Check enable |
| cfg_odd | input | 1 | Parity sense: 1 odd, 0 even |
| acc_en | input | 1 | Access to peripheral RAM this cycle |
| acc_we | input | 1 | Access is a write |
| acc_addr | input | ADDR_W | Access address |
| acc_wdata | input | DATA_W | Write data |
| ram_rdata | input | DATA_W | Data returned by peripheral RAM, valid the cycle after a read |
| cap_clr | input | 1 | Clear capture and overflow |
| err_pulse | output | 1 | One-cycle parity error pulse |
| err_lanes | output | DATA_W/LANE_W | Failing lane mask, valid with the pulse |
| cap_valid | output | 1 | A failing address is held |
| cap_addr | output | ADDR_W | Address of first failing read |
| cap_overflow | output | 1 | Further error occurred before clear |

## Verification
Properties checked on every cycle:
- A pulse only ever follows a read request.
- Checking off silences the pulse.
- The held address stays frozen until a clear.
- Overflow never stands without a capture.
- A clear with no coincident error empties the capture.
- A rising capture carries the address of the read that failed.

Only the bench scenarios can show the following:
- The stored parity is correct for odd and even sense.
- The lane mask matches the exact bits corrupted.
- Even-count flips inside a lane go unnoticed.
- A polarity change flags every lane.
- A clear and an error in the same cycle give a fresh capture.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
  function automatic int lane_count(input int data_w, input int lane_w);
    return data_w / lane_w;
  endfunction
endpackage

// File: rtl/ppg_lane_parity.sv
module ppg_lane_parity #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES = ppg_pkg::lane_count(DATA_W, LANE_W)
) (
  input  logic [DATA_W-1:0] data,
  input  logic              odd,
  output logic [LANES-1:0]  par
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign par[i] = (^data[i*LANE_W +: LANE_W]) ^ odd;
  end
endmodule

// File: rtl/ppg_parity_store.sv
module ppg_parity_store #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  wpar,
  output logic [LANES-1:0]  rpar
);
  logic [LANES-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr) mem[addr] <= wpar;
    if (rd) rpar <= mem[addr];
  end
endmodule

// File: rtl/ppg_err_capture.sv
module ppg_err_capture #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic [ADDR_W-1:0] hit_addr,
  input  logic              clr,
  output logic              cap_valid,
  output logic [ADDR_W-1:0] cap_addr,
  output logic              cap_overflow
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_valid    <= 1'b0;
      cap_addr     <= '0;
      cap_overflow <= 1'b0;
    end else begin
      if (clr) begin
        cap_valid    <= 1'b0;
        cap_overflow <= 1'b0;
      end
      if (hit) begin
        if (cap_valid && !clr) begin
          cap_overflow <= 1'b1;
        end else begin
          cap_valid <= 1'b1;
          cap_addr  <= hit_addr;
        end
      end
    end
  end

  p_first_capture_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(cap_valid) |-> ($past(hit) && cap_addr == $past(hit_addr)));

  p_addr_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(cap_valid) && !$past(clr)) |-> (cap_valid && $stable(cap_addr)));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    cap_overflow |-> cap_valid);

  p_clear_empties_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(clr) && !$past(hit)) |-> (!cap_valid && !cap_overflow));
endmodule

// File: rtl/pram_parity_guard.sv
module pram_parity_guard #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES = ppg_pkg::lane_count(DATA_W, LANE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en,
  input  logic              cfg_odd,
  input  logic              acc_en,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic [DATA_W-1:0] ram_rdata,
  input  logic              cap_clr,
  output logic              err_pulse,
  output logic [LANES-1:0]  err_lanes,
  output logic              cap_valid,
  output logic [ADDR_W-1:0] cap_addr,
  output logic              cap_overflow
);
  logic             wr_req, rd_req;
  logic [LANES-1:0] wr_par, calc_par, stored_par, mm_lanes;
  logic             rd_pend_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic             hit;

  assign wr_req = acc_en && acc_we;
  assign rd_req = acc_en && !acc_we;

  ppg_lane_parity #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_wgen (
    .data(acc_wdata), .odd(cfg_odd), .par(wr_par));

  ppg_lane_parity #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_rgen (
    .data(ram_rdata), .odd(cfg_odd), .par(calc_par));

  ppg_parity_store #(.ADDR_W(ADDR_W), .LANES(LANES)) u_store (
    .clk(clk), .wr(wr_req), .rd(rd_req), .addr(acc_addr),
    .wpar(wr_par), .rpar(stored_par));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend_q <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      rd_pend_q <= rd_req;
      if (rd_req) rd_addr_q <= acc_addr;
    end
  end

  assign mm_lanes = (rd_pend_q && cfg_en) ? (calc_par ^ stored_par) : '0;
  assign hit      = |mm_lanes;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_pulse <= 1'b0;
      err_lanes <= '0;
    end else begin
      err_pulse <= hit;
      err_lanes <= mm_lanes;
    end
  end

  ppg_err_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst(rst), .hit(hit), .hit_addr(rd_addr_q), .clr(cap_clr),
    .cap_valid(cap_valid), .cap_addr(cap_addr), .cap_overflow(cap_overflow));

  p_pulse_after_read_r2: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> $past(rd_pend_q));

  p_quiet_when_off_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_en) |-> (!err_pulse && err_lanes == '0));
endmodule

// File: tb/pram_parity_guard_test.sv
`timescale 1ns/1ps
module pram_parity_guard_test;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;
  localparam int LANE_W = 8;
  localparam int LANES  = DATA_W / LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_en = 1'b1, cfg_odd = 1'b0, acc_en = 1'b0, acc_we = 1'b0, cap_clr = 1'b0;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic [DATA_W-1:0] acc_wdata = '0, ram_rdata = '0;
  logic err_pulse, cap_valid, cap_overflow;
  logic [LANES-1:0] err_lanes;
  logic [ADDR_W-1:0] cap_addr;

  always #2 clk = ~clk;

  pram_parity_guard #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) uut (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_odd(cfg_odd), .acc_en(acc_en),
    .acc_we(acc_we), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .ram_rdata(ram_rdata), .cap_clr(cap_clr), .err_pulse(err_pulse),
    .err_lanes(err_lanes), .cap_valid(cap_valid), .cap_addr(cap_addr),
    .cap_overflow(cap_overflow));

  logic [DATA_W-1:0] model [DEPTH];
  logic              wodd  [DEPTH];
  logic              wrote [DEPTH];
  logic              e_valid = 1'b0, e_ovf = 1'b0;
  logic [ADDR_W-1:0] e_addr = '0;
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [LANES-1:0] exp_lanes(input logic [DATA_W-1:0] c,
                                                 input logic ow, input logic orr);
    logic [LANES-1:0] r;
    for (int i = 0; i < LANES; i++) r[i] = (^c[i*LANE_W +: LANE_W]) ^ ow ^ orr;
    return r;
  endfunction

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_we = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_en = 1'b0; acc_we = 1'b0;
    model[a] = d; wodd[a] = cfg_odd; wrote[a] = 1'b1;
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] corrupt,
                         input logic en_v, input logic clr_v);
    logic [LANES-1:0] el;
    logic h;
    @(negedge clk);
    acc_en = 1'b1; acc_we = 1'b0; acc_addr = a;
    @(negedge clk);
    acc_en = 1'b0;
    ram_rdata = model[a] ^ corrupt;
    cfg_en = en_v; cap_clr = clr_v;
    el = en_v ? exp_lanes(corrupt, wodd[a], cfg_odd) : '0;
    h = |el;
    if (clr_v) begin e_valid = 1'b0; e_ovf = 1'b0; end
    if (h) begin
      if (e_valid) e_ovf = 1'b1;
      else begin e_valid = 1'b1; e_addr = a; end
    end
    @(negedge clk);
    cap_clr = 1'b0; cfg_en = 1'b1;
    check("R2 pulse", {63'd0, err_pulse}, {63'd0, h});
    check("R3 lanes", {{(64-LANES){1'b0}}, err_lanes}, {{(64-LANES){1'b0}}, el});
    check("R5 valid", {63'd0, cap_valid}, {63'd0, e_valid});
    check("R6 addr", {{(64-ADDR_W){1'b0}}, cap_addr}, {{(64-ADDR_W){1'b0}}, e_addr});
    check("R7 ovf", {63'd0, cap_overflow}, {63'd0, e_ovf});
    @(negedge clk);
    check("R2 single cycle", {63'd0, err_pulse}, 64'd0);
  endtask

  task automatic do_clear();
    @(negedge clk); cap_clr = 1'b1;
    @(negedge clk); cap_clr = 1'b0;
    e_valid = 1'b0; e_ovf = 1'b0;
    check("R8 clear valid", {63'd0, cap_valid}, 64'd0);
    check("R8 clear ovf", {63'd0, cap_overflow}, 64'd0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    for (int i = 0; i < DEPTH; i++) begin model[i] = '0; wodd[i] = 1'b0; wrote[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 pulse", {63'd0, err_pulse}, 64'd0);
    check("R11 lanes", {{(64-LANES){1'b0}}, err_lanes}, 64'd0);
    check("R11 valid", {63'd0, cap_valid}, 64'd0);
    check("R11 addr", {{(64-ADDR_W){1'b0}}, cap_addr}, 64'd0);
    check("R11 ovf", {63'd0, cap_overflow}, 64'd0);

    // R1 clean even and odd
    do_write(6'd3, 32'hA5A5_0F01);
    do_read(6'd3, 32'h0, 1'b1, 1'b0);
    cfg_odd = 1'b1;
    do_write(6'd4, 32'h1234_5678);
    do_read(6'd4, 32'h0, 1'b1, 1'b0);
    // R4 two flips in one lane
    do_read(6'd4, 32'h0003_0000, 1'b1, 1'b0);
    // R3 R5 single flip in lane 2
    do_read(6'd4, 32'h0010_0000, 1'b1, 1'b0);
    // R6 R7 second error elsewhere
    cfg_odd = 1'b0;
    do_read(6'd3, 32'h8000_0001, 1'b1, 1'b0);
    do_clear();
    // R9 disabled: no pulse, no capture
    do_read(6'd3, 32'h0000_0100, 1'b0, 1'b0);
    // R10 polarity mismatch: written odd, read even
    do_read(6'd4, 32'h0, 1'b1, 1'b0);
    // R8 clear coinciding with error: fresh capture
    do_read(6'd3, 32'h0000_0001, 1'b1, 1'b0);
    do_read(6'd3, 32'h0100_0000, 1'b1, 1'b1);
    check("R8 fresh addr", {{(64-ADDR_W){1'b0}}, cap_addr}, 64'd3);
    do_clear();
    // R1 write stored while disabled
    cfg_en = 1'b0;
    do_write(6'd9, 32'hFFFF_0000);
    cfg_en = 1'b1;
    do_read(6'd9, 32'h0, 1'b1, 1'b0);

    for (int n = 0; n < 400; n++) begin
      logic [ADDR_W-1:0] a;
      logic [DATA_W-1:0] c;
      a = ADDR_W'($urandom % DEPTH);
      if ($urandom % 10 == 0) cfg_odd = ~cfg_odd;
      if (!wrote[a] || $urandom % 3 == 0) do_write(a, $urandom);
      c = ($urandom % 3 == 0) ? DATA_W'($urandom) : '0;
      do_read(a, c, ($urandom % 8) != 0, ($urandom % 6) == 0);
      if ($urandom % 15 == 0) do_clear();
    end

    done = 1;
    summary();
    $finish;
  end
endmodule